// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block sits behind a CAN frame decoder. For every received identifier it decides whether any of sixteen message buffers should take the frame, and if so which one. The decoder presents the identifier, a flag that tells standard (11-bit) from extended (29-bit) format, and a one-cycle strobe. Two clock edges later the filter reports a hit flag and the index of the winning buffer, and pulses a store strobe when the frame is to be kept.

Each buffer has its own enable, format, identifier and filter mode, and the host writes these through a simple write-only register port. The filter modes are:

- exact: every identifier bit counts;
- all-masked: any identifier of the right format is taken;
- through shared mask A;
- through shared mask B.

In a mask, a 1 bit marks a don't-care position. When several buffers accept the same frame, the lowest-numbered one wins.

Top module: `can_accept_filter`

## Requirements
- R1: After a synchronous active-low reset, `acc_hit`, `acc_idx` and `acc_store` are 0, and every buffer is disabled, so no frame hits until the host enables one.
- R2: An extended frame (`rx_ext`=1) hits an enabled extended buffer in exact mode (mode code 0) only when all 29 bits of `rx_id` equal the buffer identifier. A difference in any single bit gives no hit.
- R3: For a standard frame (`rx_ext`=0), only bits 10:0 of `rx_id` and of the buffer identifier are compared. Bits 28:11 of both are ignored.
- R4: A buffer never hits a frame whose format differs from its format bit (1 = extended, 0 = standard), in any mode.
- R5: In all-masked mode (code 1), an enabled buffer hits every frame of its own format.
- R6: In mode 2 the comparison goes through mask A, and in mode 3 through mask B. A mask bit of 1 makes that identifier bit a don't-care. Each buffer selects its mask on its own.
- R7: When several buffers hit, `acc_idx` is the lowest-numbered of them.
- R8: A disabled buffer never hits, whatever its mode.
- R9: A frame strobe sampled at clock edge k updates `acc_hit` and `acc_idx` at edge k+1; they then hold until the next frame. `acc_store` is 1 for exactly the cycle after edge k+1, and only if there was a hit. With no hit, `acc_idx` is 0.
- R10: A configuration write sampled at an edge before the frame strobe's edge applies to that frame. A write sampled at the same edge as the strobe applies only from the next frame on.
- R11: The host writes on a rising edge when `cfg_we`=1. The register map is:

  | Address | Contents |
  |---|---|
  | 2·b | identifier of buffer b, in `cfg_wdata[28:0]` |
  | 2·b+1 | control of buffer b: bit 0 enable, bit 1 format, bits 3:2 mode |
  | 32 | mask A, in `cfg_wdata[28:0]` |
  | 33 | mask B, in `cfg_wdata[28:0]` |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Host write enable |
| cfg_addr | input | 6 | Host register address |
| cfg_wdata | input | 32 | Host write data |
| rx_valid | input | 1 | One-cycle strobe: a received identifier is present |
| rx_ext | input | 1 | Frame format, 1 = extended, 0 = standard |
| rx_id | input | 29 | Received identifier (standard format uses bits 10:0) |
| acc_hit | output | 1 | Last frame hit some buffer |
| acc_idx | output | 4 | Winning buffer index of the last frame |
| acc_store | output | 1 | One-cycle pulse: store the frame in buffer `acc_idx` |

## Verification
The hardest situation to reach from the ports is a host write that lands on the same edge as a frame strobe. There the old and the new configuration differ by one enable bit. The stimulus drives the write and the strobe on the same falling edge, then repeats the frame alone to show the new setting took effect. The set-up also has buffers that overlap on purpose. A duplicate of buffer 0 sits at a higher index, an all-masked catch-all at index 5, a disabled extended catch-all, and a standard buffer whose upper identifier bits are junk. As a result, single frames test priority, format isolation, the disable gate and the 11-bit truncation together.

// File: rtl/can_filt_pkg.sv
// Shared types for the CAN acceptance filter.
// Assumes the protocol fixes the identifier widths (29 extended, 11 standard).
package can_filt_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        FM_EXACT  = 2'd0,
        FM_ALL    = 2'd1,
        FM_MASK_A = 2'd2,
        FM_MASK_B = 2'd3
    } filt_mode_e;

    typedef struct packed {
        logic            en;
        logic            ext;
        filt_mode_e      mode;
        logic [ID_W-1:0] id;
    } buf_cfg_t;
endpackage

// File: rtl/can_filt_regs.sv
// Host-written configuration store: per-buffer identifier and control words,
// plus the two shared masks. Write-only; assumes one write per cycle at most.
module can_filt_regs
    import can_filt_pkg::*;
#(
    parameter int NUM_BUF = 16,
    parameter int ADDR_W  = $clog2(2*NUM_BUF+2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output buf_cfg_t [NUM_BUF-1:0]    cfg_o,
    output logic [ID_W-1:0]           mask_a_o,
    output logic [ID_W-1:0]           mask_b_o
);
    localparam int MASK_A_ADDR = 2*NUM_BUF;
    localparam int MASK_B_ADDR = 2*NUM_BUF + 1;

    logic wdata_unused;
    assign wdata_unused = ^wdata_i[DATA_W-1:ID_W];

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        // Update one buffer's identifier or control word on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[b] <= '0;
            end else if (we_i && addr_i == ADDR_W'(2*b)) begin
                cfg_o[b].id <= wdata_i[ID_W-1:0];
            end else if (we_i && addr_i == ADDR_W'(2*b+1)) begin
                cfg_o[b].en   <= wdata_i[0];
                cfg_o[b].ext  <= wdata_i[1];
                cfg_o[b].mode <= filt_mode_e'(wdata_i[3:2]);
            end
        end
    end

    // Update the shared masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a_o <= '0;
            mask_b_o <= '0;
        end else if (we_i) begin
            if (addr_i == ADDR_W'(MASK_A_ADDR)) mask_a_o <= wdata_i[ID_W-1:0];
            if (addr_i == ADDR_W'(MASK_B_ADDR)) mask_b_o <= wdata_i[ID_W-1:0];
        end
    end
endmodule

// File: rtl/can_filt_match.sv
// Combinational compare of one received identifier against one buffer.
// Assumes standard identifiers sit in bits 10:0; a mask bit of 1 is don't-care.
module can_filt_match
    import can_filt_pkg::*;
(
    input  buf_cfg_t        cfg_i,
    input  logic [ID_W-1:0] mask_a_i,
    input  logic [ID_W-1:0] mask_b_i,
    input  logic            rx_ext_i,
    input  logic [ID_W-1:0] rx_id_i,
    output logic            match_o
);
    localparam logic [ID_W-1:0] STD_BITS = ID_W'((1 << STD_W) - 1);

    logic [ID_W-1:0] ignore;
    logic [ID_W-1:0] width_sel;
    logic [ID_W-1:0] diff;

    // Choose which identifier bits are don't-care for this buffer's mode.
    always_comb begin
        unique case (cfg_i.mode)
            FM_EXACT:  ignore = '0;
            FM_ALL:    ignore = '1;
            FM_MASK_A: ignore = mask_a_i;
            FM_MASK_B: ignore = mask_b_i;
            default:   ignore = '0;
        endcase
    end

    // Compare the significant, unmasked bits and gate by enable and format.
    always_comb begin
        width_sel = rx_ext_i ? '1 : STD_BITS;
        diff      = (rx_id_i ^ cfg_i.id) & ~ignore & width_sel;
        match_o   = cfg_i.en && (cfg_i.ext == rx_ext_i) && (diff == '0);
    end
endmodule

// File: rtl/can_filt_prio.sv
// Fixed-priority pick: the lowest set request bit wins.
// Assumes IDX_W is wide enough to index N requests.
module can_filt_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] below;

    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    // Build the set of bits below the chosen index, used by the check.
    always_comb below = (N'(1) << idx_o) - N'(1);

    // Confirm the winner requested and nothing lower did.
    always_comb begin
        if (hit_o) begin
            // R7
            lowest_win_chk: assert (req_i[idx_o] && ((req_i & below) == '0));
        end
    end
endmodule

// File: rtl/can_accept_filter.sv
// CAN acceptance filter top: per-buffer compare, registered match vector,
// priority pick, registered result and store strobe (two-edge latency).
// Assumes rx_valid is a single-cycle strobe from the frame decoder.
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_BUF = 16,
    localparam int IDX_W  = $clog2(NUM_BUF),
    localparam int ADDR_W = $clog2(2*NUM_BUF+2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_ext,
    input  logic [ID_W-1:0]   rx_id,
    output logic              acc_hit,
    output logic [IDX_W-1:0]  acc_idx,
    output logic              acc_store
);
    buf_cfg_t [NUM_BUF-1:0] cfg;
    logic [ID_W-1:0]        mask_a, mask_b;
    logic [NUM_BUF-1:0]     match_vec, match_q;
    logic [NUM_BUF-1:0]     en_vec, ext_vec;
    logic                   valid_q;
    logic                   win_hit;
    logic [IDX_W-1:0]       win_idx;

    can_filt_regs #(.NUM_BUF(NUM_BUF), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .addr_i   (cfg_addr),
        .wdata_i  (cfg_wdata),
        .cfg_o    (cfg),
        .mask_a_o (mask_a),
        .mask_b_o (mask_b)
    );

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_match
        assign en_vec[b]  = cfg[b].en;
        assign ext_vec[b] = cfg[b].ext;

        can_filt_match u_match (
            .cfg_i    (cfg[b]),
            .mask_a_i (mask_a),
            .mask_b_i (mask_b),
            .rx_ext_i (rx_ext),
            .rx_id_i  (rx_id),
            .match_o  (match_vec[b])
        );

        // R8
        disabled_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && match_q[b]) |-> $past(en_vec[b]));

        // R4
        format_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && match_q[b]) |-> ($past(ext_vec[b]) == $past(rx_ext)));
    end

    // Stage 1: capture the match vector of the strobed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            match_q <= '0;
        end else begin
            valid_q <= rx_valid;
            if (rx_valid) match_q <= match_vec;
        end
    end

    can_filt_prio #(.N(NUM_BUF), .IDX_W(IDX_W)) u_prio (
        .req_i (match_q),
        .hit_o (win_hit),
        .idx_o (win_idx)
    );

    // Stage 2: register the winner and pulse the store strobe on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hit   <= 1'b0;
            acc_idx   <= '0;
            acc_store <= 1'b0;
        end else begin
            acc_store <= valid_q && win_hit;
            if (valid_q) begin
                acc_hit <= win_hit;
                acc_idx <= win_idx;
            end
        end
    end

    // R9
    store_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_store |-> $past(rx_valid, 2));

    // R9
    store_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_store |-> acc_hit);

    // R9
    result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_q) |-> ($stable(acc_hit) && $stable(acc_idx)));
endmodule

// File: tb/tb_can_accept_filter.sv
// Self-checking bench: vector table walked by one loop, then directed tests.
module tb_can_accept_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ext = 1'b0;
    logic [28:0] rx_id = '0;
    logic        acc_hit;
    logic [3:0]  acc_idx;
    logic        acc_store;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_ext(rx_ext),
        .rx_id(rx_id), .acc_hit(acc_hit), .acc_idx(acc_idx), .acc_store(acc_store)
    );

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic        hit;
        logic [3:0]  idx;
        logic [3:0]  req;
    } vec_t;

    // Expected results follow from the buffer set-up in the main block.
    localparam vec_t VECS [12] = '{
        '{1'b1, 29'h1ABCDE01, 1'b1, 4'd0, 4'd7},  // R2, R7: buffer 6 duplicates 0
        '{1'b1, 29'h1ABCDE00, 1'b0, 4'd0, 4'd8},  // R2 one bit off; R8 buffer 4 off
        '{1'b0, 29'h1FFFF123, 1'b1, 4'd1, 4'd3},  // R3 upper bits ignored
        '{1'b0, 29'h00000125, 1'b1, 4'd2, 4'd6},  // R6 mask A, standard
        '{1'b0, 29'h00000130, 1'b1, 4'd5, 4'd5},  // R5 catch-all
        '{1'b1, 29'h00AB1234, 1'b1, 4'd3, 4'd6},  // R6 mask B, extended
        '{1'b1, 29'h00AC1234, 1'b0, 4'd0, 4'd6},  // R6 unmasked bit differs
        '{1'b1, 29'h1F000007, 1'b1, 4'd7, 4'd6},  // R6 mask A, extended
        '{1'b1, 29'h00000123, 1'b0, 4'd0, 4'd4},  // R4 standard buffers skip extended
        '{1'b0, 29'h1ABCDE01, 1'b1, 4'd5, 4'd4},  // R4 extended buffers skip standard
        '{1'b0, 29'h000007FF, 1'b1, 4'd5, 4'd5},  // R5
        '{1'b1, 29'h1F000017, 1'b0, 4'd0, 4'd6}   // R6 bit outside mask A
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobe one frame, then check the result at the edge after next.
    task automatic frame(input string req, input logic ext, input logic [28:0] id,
                         input logic hit, input logic [3:0] idx);
        @(negedge clk);
        rx_valid = 1'b1; rx_ext = ext; rx_id = id;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(req, "store early", {31'd0, acc_store}, 32'd0);
        @(negedge clk);
        chk(req, "store", {31'd0, acc_store}, {31'd0, hit});
        chk(req, "hit", {31'd0, acc_hit}, {31'd0, hit});
        chk(req, "idx", {28'd0, acc_idx}, {28'd0, hit ? idx : 4'd0});
        @(negedge clk);
        chk(req, "store pulse end", {31'd0, acc_store}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "hit", {31'd0, acc_hit}, 32'd0);
        chk("R1", "idx", {28'd0, acc_idx}, 32'd0);
        chk("R1", "store", {31'd0, acc_store}, 32'd0);
        frame("R1", 1'b0, 29'h130, 1'b0, 4'd0);
        frame("R1", 1'b1, 29'h0, 1'b0, 4'd0);

        // R11 configuration: control = {mode, ext, en}
        wr(6'd0, 32'h1ABCDE01); wr(6'd1, 32'h3);   // b0 ext exact
        wr(6'd2, 32'h0ABCD123); wr(6'd3, 32'h1);   // b1 std exact
        wr(6'd4, 32'h120);      wr(6'd5, 32'h9);   // b2 std mask A
        wr(6'd6, 32'h00AB0000); wr(6'd7, 32'hF);   // b3 ext mask B
        wr(6'd9, 32'h6);                           // b4 ext all, disabled
        wr(6'd11, 32'h5);                          // b5 std all
        wr(6'd12, 32'h1ABCDE01); wr(6'd13, 32'h3); // b6 ext exact duplicate
        wr(6'd14, 32'h1F000000); wr(6'd15, 32'hB); // b7 ext mask A
        wr(6'd32, 32'hF);
        wr(6'd33, 32'hFFFF);

        for (int v = 0; v < 12; v++) begin
            frame($sformatf("R%0d", VECS[v].req), VECS[v].ext, VECS[v].id,
                  VECS[v].hit, VECS[v].idx);
        end

        // R9 result holds after the pulse
        frame("R9", 1'b1, 29'h1ABCDE01, 1'b1, 4'd0);
        @(negedge clk);
        chk("R9", "hit held", {31'd0, acc_hit}, 32'd1);
        chk("R9", "store idle", {31'd0, acc_store}, 32'd0);

        // R8 disable the catch-all
        wr(6'd11, 32'h4);
        frame("R8", 1'b0, 29'h130, 1'b0, 4'd0);

        // R10 write on the same edge as the strobe: old setting applies
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd11; cfg_wdata = 32'h5;
        rx_valid = 1'b1; rx_ext = 1'b0; rx_id = 29'h130;
        @(negedge clk);
        cfg_we = 1'b0; rx_valid = 1'b0;
        @(negedge clk);
        chk("R10", "same-edge write", {31'd0, acc_hit}, 32'd0);
        frame("R10", 1'b0, 29'h130, 1'b1, 4'd5);

        // R6 switch buffer 2 to mask B, which covers all 11 standard bits
        wr(6'd5, 32'hD);
        frame("R6", 1'b0, 29'h7FF, 1'b1, 4'd2);
        frame("R7", 1'b0, 29'h123, 1'b1, 4'd1);

        summary();
        $finish;
    end
endmodule